// File: doc/BRIEF.md
# Clock-Gated Mode-Select Shift Register

This block is a small storage register, four bits wide by default, that can be loaded in parallel, read in parallel at all times, and shifted one place toward the least significant bit with a serial bit entering at the top. A two-bit mode selector picks the operation. Two of the four selector codes mean "keep the contents". For those codes the storage flops are not clocked at all. They do not reload their own value through a multiplexer.

The gating enable is the exclusive-OR of the two selector bits. A latch that is open while the clock is low captures this enable. The latch output is ANDed with the free-running clock, so the gated clock carries only whole high pulses. The captured enable is also driven out of the block so that the gating activity can be observed. The selector bits are expected to change only while the clock is low, for example from flops on the falling edge. A change during the high phase has no effect until the clock falls.

Reset is synchronous and active low. While reset is asserted the gate is forced open, so the register clears on the next clock edge whatever the selector holds.

Top module: `shreg_gated`

## Requirements
- R1: The width is set by the parameter WIDTH (default 4). `par_out` always shows every stored bit, with bit WIDTH-1 as the most significant.
- R2: With {mode_s1, mode_s0} = 2'b01 at a rising clock edge, the register shifts right by one place: bit WIDTH-1 takes `ser_in`, bit i takes the old bit i+1, and the old bit 0 is discarded.
- R3: With {mode_s1, mode_s0} = 2'b10 at a rising clock edge, the register takes `par_in`, with bit i of `par_in` going to bit i.
- R4: With {mode_s1, mode_s0} = 2'b00, the contents do not change, whatever `ser_in` and `par_in` hold.
- R5: With {mode_s1, mode_s0} = 2'b11, the contents do not change, whatever `ser_in` and `par_in` hold.
- R6: Outside reset, during the clock-high phase `gclk_en` equals mode_s1 XOR mode_s0 as it stood at the end of the preceding low phase. The storage flops therefore see no clock edge in modes 00 and 11.
- R7: If `rst_n` is low at a rising clock edge, `par_out` becomes all zeros after that edge whatever the mode. During reset `gclk_en` reads 1.
- R8: A change of the selector bits while the clock is high leaves `gclk_en` unchanged until the clock goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_s1 | input | 1 | Mode select, upper bit |
| mode_s0 | input | 1 | Mode select, lower bit |
| ser_in | input | 1 | Serial bit shifted into the MSB |
| par_in | input | WIDTH | Parallel load data |
| par_out | output | WIDTH | Parallel read of the stored bits |
| gclk_en | output | 1 | Latched clock-gate enable, for observation |

## Verification
The bench builds the block with the default WIDTH of 4. At this width four consecutive shifts fully replace the old contents with serial bits. This lets the bench test a complete drain and every bit position of a parallel load in a short run. The bench mixes all four selector codes, with the data inputs toggling during the keep codes. It runs the result against an ungated reference register, and it changes the selector during the high phase to check the latch timing.

// File: rtl/shreg_pkg.sv
// Package: shared mode encoding for the clock-gated shift register.
// Assumes the selector is presented as {s1, s0}.
package shreg_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_SHIFT = 2'b01,
        MODE_LOAD  = 2'b10,
        MODE_PARK  = 2'b11
    } shreg_mode_e;
endpackage

// File: rtl/shreg_mode_dec.sv
// Mode decoder: turns the two selector bits into a mode value and a clock-gate
// request. The request is the XOR of the bits. Reset forces the request high
// so that the synchronous reset reaches the flops. Assumes the selector is
// stable while the clock is high.
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic        sel_hi,
    input  logic        sel_lo,
    input  logic        rst_n,
    output shreg_mode_e mode,
    output logic        gate_req
);
    // Purpose: assemble the selector and form the gate request.
    always_comb begin
        mode     = shreg_mode_e'({sel_hi, sel_lo});
        gate_req = (sel_hi ^ sel_lo) | ~rst_n;
    end
endmodule

// File: rtl/shreg_icg.sv
// Integrated clock gate written as behaviour: a latch that is open while the
// clock is low holds the enable, and its output is ANDed with the clock. Each
// gated pulse is therefore either a whole clock-high phase or absent.
module shreg_icg (
    input  logic clk,
    input  logic en_req,
    output logic en_held,
    output logic gclk
);
    // Purpose: capture the request only during the low phase.
    always_latch begin
        if (!clk) en_held <= en_req;
    end

    // Purpose: pass the clock only when the held enable is set.
    always_comb gclk = clk & en_held;
endmodule

// File: rtl/shreg_store.sv
// Storage: WIDTH flops clocked by the gated clock. Does a right shift or a
// parallel load. The keep modes never get an edge here. The free clock is an
// input only so that the checks next to the flops can sample it.
module shreg_store
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_free,
    input  logic             gclk,
    input  logic             rst_n,
    input  shreg_mode_e      mode,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] q_next;

    // Purpose: choose the next contents for the modes that can clock.
    always_comb begin
        unique case (mode)
            MODE_SHIFT: q_next = {ser_in, q[MSB:1]};
            MODE_LOAD:  q_next = par_in;
            default:    q_next = q;
        endcase
    end

    // Purpose: update the bits on gated edges; synchronous clear.
    always_ff @(posedge gclk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // R2
    shift_chk: assert property (@(posedge clk_free) disable iff (!rst_n)
        (mode == MODE_SHIFT) |=> (q == {$past(ser_in), $past(q[MSB:1])}));
    // R3
    load_chk: assert property (@(posedge clk_free) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in)));
    // R4 R5
    keep_chk: assert property (@(posedge clk_free) disable iff (!rst_n)
        (mode == MODE_IDLE || mode == MODE_PARK) |=> $stable(q));
    // R7
    clear_chk: assert property (@(posedge clk_free)
        (!rst_n) |=> (q == '0));
endmodule

// File: rtl/shreg_gated.sv
// Top: shift register with mode-driven clock gating. The decoder forms the
// gate request, the latch gate produces the gated clock, and the store holds
// the bits. Assumes the selector changes only while clk is low.
module shreg_gated
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_s1,
    input  logic             mode_s0,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             gclk_en
);
    shreg_mode_e mode;
    logic        gate_req;
    logic        gclk;

    shreg_mode_dec dec_i (
        .sel_hi  (mode_s1),
        .sel_lo  (mode_s0),
        .rst_n   (rst_n),
        .mode    (mode),
        .gate_req(gate_req)
    );

    shreg_icg icg_i (
        .clk    (clk),
        .en_req (gate_req),
        .en_held(gclk_en),
        .gclk   (gclk)
    );

    shreg_store #(.WIDTH(WIDTH)) store_i (
        .clk_free(clk),
        .gclk    (gclk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .q       (par_out)
    );

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s1 == mode_s0) |-> !gclk_en);
    // R6
    gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s1 != mode_s0) |-> gclk_en);
    // R7
    rst_open_chk: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> gclk_en);
endmodule

// File: tb/shreg_gated_tb_top.sv
// Scoreboard bench: the driver applies one step on each falling edge and
// pushes the expected output of an ungated reference register. The monitor
// pops one entry in each high phase and compares it.
module shreg_gated_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s1 = 1'b0, s0 = 1'b0, sin = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] pout;
    logic         gen;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct packed {
        logic [W-1:0] q;
        logic         en;
        logic [7:0]   req;
    } exp_t;
    exp_t exp_q[$];
    logic [W-1:0] ref_q = '0;

    always #5 clk = ~clk;

    shreg_gated #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_s1(s1), .mode_s0(s0),
        .ser_in(sin), .par_in(pin), .par_out(pout), .gclk_en(gen)
    );

    // Driver: one cycle of stimulus plus the reference model update.
    task automatic step(input logic r, input logic a, input logic b,
                        input logic si, input logic [W-1:0] pi, input logic [7:0] rq);
        exp_t e;
        @(negedge clk);
        rst_n = r; s1 = a; s0 = b; sin = si; pin = pi;
        if (!r)               ref_q = '0;
        else if ({a, b} == 2'b01) ref_q = {si, ref_q[W-1:1]};
        else if ({a, b} == 2'b10) ref_q = pi;
        e.q = ref_q; e.en = !r ? 1'b1 : (a ^ b); e.req = rq;
        exp_q.push_back(e);
    endtask

    // Monitor: compare mid-high-phase outputs with the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                tests++;
                if (pout !== e.q || gen !== e.en) begin
                    fails++;
                    $display("FAIL R%0s: par_out=%h gclk_en=%b expected par_out=%h gclk_en=%b",
                             (e.req == 8'd1) ? "1" : (e.req == 8'd2) ? "2" : (e.req == 8'd3) ? "3" :
                             (e.req == 8'd4) ? "4" : (e.req == 8'd5) ? "5" : (e.req == 8'd6) ? "6" : "7",
                             pout, gen, e.q, e.en);
                end
            end
        end
    end

    // Main sequence.
    initial begin
        // R7: reset state, gate open during reset
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 8'd7);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'hA, 8'd7);
        // R3 R1: load each bit position
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'h1, 8'd3);
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'h2, 8'd3);
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'h4, 8'd3);
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'h8, 8'd1);
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'hA, 8'd3);
        // R4: idle with toggling data
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'h5, 8'd4);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd4);
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 8'd6);
        // R2: full drain by four shifts
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'd2);
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 8'd2);
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'h3, 8'd2);
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'hC, 8'd2);
        // R5: park with toggling data
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'h9, 8'd5);
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'h6, 8'd5);
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'h3, 8'd6);
        // R8: selector changes in the high phase must not reach gclk_en
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'd2);
        @(posedge clk); #3;
        s1 = 1'b0; s0 = 1'b0;
        #1;
        tests++;
        if (gen !== 1'b1) begin
            fails++;
            $display("FAIL R8: gclk_en=%b expected 1", gen);
        end
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd4);
        // mixed pattern against the reference model (R2 R3 R4 R5 R6)
        for (int i = 0; i < 40; i++) begin
            logic [1:0] m;
            m = 2'((i * 7 + i / 3) % 4);
            step(1'b1, m[1], m[0], 1'((i * 5) % 3 == 0), 4'((i * 11 + 3) % 16),
                 m == 2'b01 ? 8'd2 : m == 2'b10 ? 8'd3 : 8'd6);
        end
        // R7: reset in a keep mode with nonzero contents clears
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'hD, 8'd3);
        step(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 8'd7);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd7);
        @(posedge clk); #4;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1: watchdog expired, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule